// File: doc/BRIEF.md
# Transmit Packet Buffer with Collision Replay and Underrun Retry

This block is a 2048-byte transmit buffer. It sits between a host-side write port, fed by a DMA engine, and a byte-wide read port that a MAC drains. Frames are written one byte at a time, and the final byte carries an end marker. The buffer holds at most two complete frames. While one frame is being sent, the next can be fetched in full, so it is ready to leave as soon as the current one ends. A frame is offered to the MAC when its buffered byte count reaches a programmable drain threshold, or when its end marker has been written, whichever comes first.

Each frame stays in storage until it has left completely or been given up. If the MAC reports a collision while no more than 64 bytes of the frame have been taken, the frame is sent again from its first byte and the host is not asked for it again. A collision after that point is a late collision: it is reported and the rest of the frame is dropped.

When the MAC starves, the frame is rewound and held back until every byte of it is buffered. That full-frame hold applies to this frame only; the next frame returns to the programmed threshold. After three underrun retries of one frame have failed, the block reports failure and drops the frame.

Top module: `tx_replay_fifo`

## Requirements
- R1: After reset, wr_ready is 1 and tx_req, mac_avail and all five status pulses are 0.
- R2: Bytes reach mac_data in the order they were written, and mac_last is 1 on the byte written with wr_last. In the cycle after the MAC takes that byte, frame_sent is 1 for one cycle.
- R3: tx_req rises one cycle after the number of bytes buffered for the oldest frame reaches a nonzero drain_thresh. mac_avail is 1 only while tx_req is 1 and an unread byte is held.
- R4: A frame whose length is below drain_thresh is offered to the MAC once its end marker has been written.
- R5: At most 2 complete frames are held, and wr_ready is 0 while 2 are held. The second frame is offered one cycle after the first one's frame_sent pulse.
- R6: A mac_col while 64 or fewer bytes of the current attempt have been taken gives one col_replay pulse and drops tx_req. The frame then restarts from its first byte without any new write.
- R7: A mac_col after more than 64 bytes have been taken gives one late_col pulse. The remaining bytes of that frame are discarded without a frame_sent pulse, and the next frame starts from its own first byte.
- R8: An underrun gives a urun_retry pulse, where an underrun is mac_urun, or mac_rd while mac_avail is 0 during a frame. The frame is then held back until its end marker has been written, whatever drain_thresh is, and is resent from its first byte.
- R9: The frame after a retried frame is started at the programmed drain_thresh again.
- R10: A frame that underruns on its third retry (the fourth underrun) gives retry_fail instead of urun_retry and is discarded.
- R11: Capacity is 2048 bytes, and wr_ready is 0 while 2048 bytes are held.
- R12: At most one status pulse is 1 in any cycle. A collision takes precedence over an underrun, and an underrun takes precedence over a byte read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drain_thresh | input | 12 | Buffered byte count that lets a frame start |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Write byte ends its frame |
| wr_ready | output | 1 | Write byte is accepted on this edge |
| mac_rd | input | 1 | MAC takes the offered byte |
| mac_urun | input | 1 | MAC reports that it starved |
| mac_col | input | 1 | MAC reports a collision |
| tx_req | output | 1 | A frame is underway |
| mac_avail | output | 1 | mac_data holds a valid byte |
| mac_data | output | 8 | Offered byte |
| mac_last | output | 1 | Offered byte is the end of its frame |
| frame_sent | output | 1 | Pulse: a frame left completely |
| col_replay | output | 1 | Pulse: early collision, frame will restart |
| late_col | output | 1 | Pulse: late collision, frame dropped |
| urun_retry | output | 1 | Pulse: underrun, frame will be retried |
| retry_fail | output | 1 | Pulse: retry limit reached, frame dropped |

## Verification
All five status pulses and tx_req are registered. A status pulse shows in the cycle after the clock edge that took the collision, underrun or final read. tx_req rises one cycle after its start condition is met, because the read state machine first sees the updated write pointer and only then switches. The bench drives every input at the falling edge and samples at the next falling edge. A single rising edge therefore lies between each stimulus and the sample that checks it, and the threshold check samples both the cycle before tx_req is due and the cycle in which it rises.

// File: rtl/tx_replay_fifo_pkg.sv
`timescale 1ns/1ps
package tx_replay_fifo_pkg;

    typedef enum logic [1:0] {
        RS_WAIT  = 2'd0,
        RS_SEND  = 2'd1,
        RS_FLUSH = 2'd2
    } trf_rd_state_e;

    typedef struct packed {
        logic sent;
        logic replay;
        logic late;
        logic urun;
        logic fail;
    } trf_status_t;

endpackage

// File: rtl/trf_store.sv
`timescale 1ns/1ps
module trf_store #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W:0]   wentry,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W:0]   rentry
);
    // Each entry holds the end-of-frame flag above the data byte
    logic [DATA_W:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wentry;
        end
    end

    assign rentry = mem_q[raddr];
endmodule

// File: rtl/trf_wr_side.sv
`timescale 1ns/1ps
module trf_wr_side #(
    parameter int DEPTH      = 2048,
    parameter int MAX_FRAMES = 2,
    parameter int PTR_W      = $clog2(DEPTH) + 1,
    parameter int FCNT_W     = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic [PTR_W-1:0]  base_ptr,
    input  logic              frame_free,
    output logic              wr_ready,
    output logic              wr_accept,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [FCNT_W-1:0] frames_held
);
    localparam logic [PTR_W-1:0]  FULL_CNT = PTR_W'(DEPTH);
    localparam logic [FCNT_W-1:0] MAX_CNT  = FCNT_W'(MAX_FRAMES);

    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [FCNT_W-1:0] fcnt;
    } wr_regs_t;

    wr_regs_t r_q, r_d;
    logic [PTR_W-1:0] used;

    always_comb begin
        r_d       = r_q;
        used      = r_q.wptr - base_ptr;
        wr_ready  = (used != FULL_CNT) && (r_q.fcnt < MAX_CNT);
        wr_accept = wr_valid && wr_ready;
        if (wr_accept) begin
            r_d.wptr = r_q.wptr + 1'b1;
        end
        case ({wr_accept && wr_last, frame_free})
            2'b10:   r_d.fcnt = r_q.fcnt + 1'b1;
            2'b01:   r_d.fcnt = r_q.fcnt - 1'b1;
            default: r_d.fcnt = r_q.fcnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ptr      = r_q.wptr;
    assign frames_held = r_q.fcnt;
endmodule

// File: rtl/trf_rd_side.sv
`timescale 1ns/1ps
module trf_rd_side
    import tx_replay_fifo_pkg::*;
#(
    parameter int PTR_W      = 12,
    parameter int REPLAY_WIN = 64,
    parameter int MAX_RETRY  = 3,
    parameter int RTY_W      = $clog2(MAX_RETRY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] drain_thresh,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             head_complete,
    input  logic             ent_last,
    input  logic             mac_rd,
    input  logic             mac_urun,
    input  logic             mac_col,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] base_ptr,
    output logic             frame_free,
    output logic             tx_req,
    output logic             mac_avail,
    output trf_status_t      status
);
    localparam logic [PTR_W-1:0] WIN_CNT   = PTR_W'(REPLAY_WIN);
    localparam logic [RTY_W-1:0] RETRY_CAP = RTY_W'(MAX_RETRY);

    typedef struct packed {
        trf_rd_state_e    st;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] base;
        logic [RTY_W-1:0] rty;
        logic             hold_full;
        trf_status_t      stat;
    } rd_regs_t;

    rd_regs_t r_q, r_d;
    logic [PTR_W-1:0] buffered;
    logic [PTR_W-1:0] taken;
    logic             have_byte;
    logic             eligible;
    logic             starve;

    always_comb begin
        r_d        = r_q;
        r_d.stat   = '0;
        frame_free = 1'b0;
        buffered   = wr_ptr - r_q.base;
        taken      = r_q.rd - r_q.base;
        have_byte  = (r_q.rd != wr_ptr);
        eligible   = head_complete ||
                     (!r_q.hold_full && (buffered != '0) && (buffered >= drain_thresh));
        starve     = mac_urun || (mac_rd && !have_byte);

        case (r_q.st)
            RS_WAIT: begin
                if (eligible) begin
                    r_d.st = RS_SEND;
                end
            end
            RS_SEND: begin
                if (mac_col) begin
                    if (taken <= WIN_CNT) begin
                        r_d.rd          = r_q.base;
                        r_d.st          = RS_WAIT;
                        r_d.stat.replay = 1'b1;
                    end else begin
                        r_d.st          = RS_FLUSH;
                        r_d.rty         = '0;
                        r_d.hold_full   = 1'b0;
                        r_d.stat.late   = 1'b1;
                    end
                end else if (starve) begin
                    r_d.rd = r_q.base;
                    if (r_q.rty == RETRY_CAP) begin
                        r_d.st        = RS_FLUSH;
                        r_d.rty       = '0;
                        r_d.hold_full = 1'b0;
                        r_d.stat.fail = 1'b1;
                    end else begin
                        r_d.st        = RS_WAIT;
                        r_d.rty       = r_q.rty + 1'b1;
                        r_d.hold_full = 1'b1;
                        r_d.stat.urun = 1'b1;
                    end
                end else if (mac_rd) begin
                    r_d.rd = r_q.rd + 1'b1;
                    if (ent_last) begin
                        r_d.base      = r_q.rd + 1'b1;
                        r_d.st        = RS_WAIT;
                        r_d.rty       = '0;
                        r_d.hold_full = 1'b0;
                        r_d.stat.sent = 1'b1;
                        frame_free    = 1'b1;
                    end
                end
            end
            RS_FLUSH: begin
                if (have_byte) begin
                    r_d.rd = r_q.rd + 1'b1;
                    if (ent_last) begin
                        r_d.base   = r_q.rd + 1'b1;
                        r_d.st     = RS_WAIT;
                        frame_free = 1'b1;
                    end
                end
            end
            default: r_d.st = RS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ptr    = r_q.rd;
    assign base_ptr  = r_q.base;
    assign tx_req    = (r_q.st == RS_SEND);
    assign mac_avail = tx_req && (r_q.rd != wr_ptr);
    assign status    = r_q.stat;
endmodule

// File: rtl/tx_replay_fifo.sv
`timescale 1ns/1ps
module tx_replay_fifo
    import tx_replay_fifo_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int DATA_W     = 8,
    parameter int MAX_FRAMES = 2,
    parameter int REPLAY_WIN = 64,
    parameter int MAX_RETRY  = 3,
    parameter int TH_W       = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TH_W-1:0]   drain_thresh,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    input  logic              mac_rd,
    input  logic              mac_urun,
    input  logic              mac_col,
    output logic              tx_req,
    output logic              mac_avail,
    output logic [DATA_W-1:0] mac_data,
    output logic              mac_last,
    output logic              frame_sent,
    output logic              col_replay,
    output logic              late_col,
    output logic              urun_retry,
    output logic              retry_fail
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int FCNT_W = $clog2(MAX_FRAMES + 1);
    localparam int RTY_W  = $clog2(MAX_RETRY + 1);

    logic [PTR_W-1:0]  wr_ptr, rd_ptr, base_ptr;
    logic [FCNT_W-1:0] frames_held;
    logic              wr_accept, frame_free;
    logic [DATA_W:0]   rentry;
    trf_status_t       status;

    trf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .we     (wr_accept),
        .waddr  (wr_ptr[ADDR_W-1:0]),
        .wentry ({wr_last, wr_data}),
        .raddr  (rd_ptr[ADDR_W-1:0]),
        .rentry (rentry)
    );

    trf_wr_side #(.DEPTH(DEPTH), .MAX_FRAMES(MAX_FRAMES), .PTR_W(PTR_W),
                  .FCNT_W(FCNT_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_last     (wr_last),
        .base_ptr    (base_ptr),
        .frame_free  (frame_free),
        .wr_ready    (wr_ready),
        .wr_accept   (wr_accept),
        .wr_ptr      (wr_ptr),
        .frames_held (frames_held)
    );

    trf_rd_side #(.PTR_W(PTR_W), .REPLAY_WIN(REPLAY_WIN), .MAX_RETRY(MAX_RETRY),
                  .RTY_W(RTY_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .drain_thresh  (drain_thresh),
        .wr_ptr        (wr_ptr),
        .head_complete (frames_held != '0),
        .ent_last      (rentry[DATA_W]),
        .mac_rd        (mac_rd),
        .mac_urun      (mac_urun),
        .mac_col       (mac_col),
        .rd_ptr        (rd_ptr),
        .base_ptr      (base_ptr),
        .frame_free    (frame_free),
        .tx_req        (tx_req),
        .mac_avail     (mac_avail),
        .status        (status)
    );

    assign mac_data   = rentry[DATA_W-1:0];
    assign mac_last   = rentry[DATA_W];
    assign frame_sent = status.sent;
    assign col_replay = status.replay;
    assign late_col   = status.late;
    assign urun_retry = status.urun;
    assign retry_fail = status.fail;
endmodule

// File: rtl/trf_checker.sv
`timescale 1ns/1ps
module trf_checker #(
    parameter int MAX_FRAMES = 2,
    parameter int FCNT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ready,
    input logic              tx_req,
    input logic              mac_avail,
    input logic              frame_sent,
    input logic              col_replay,
    input logic              late_col,
    input logic              urun_retry,
    input logic              retry_fail,
    input logic [FCNT_W-1:0] frames_held
);
    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_sent, col_replay, late_col, urun_retry, retry_fail}));

    assert_avail_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mac_avail |-> tx_req);

    assert_sent_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sent |-> $past(tx_req));

    assert_replay_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_replay |-> !tx_req);

    assert_fail_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retry_fail |-> (!tx_req && !mac_avail));

    assert_frame_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frames_held == FCNT_W'(MAX_FRAMES)) |-> !wr_ready);

    assert_frame_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frames_held <= FCNT_W'(MAX_FRAMES));
endmodule

bind tx_replay_fifo trf_checker #(.MAX_FRAMES(MAX_FRAMES), .FCNT_W(FCNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ready    (wr_ready),
    .tx_req      (tx_req),
    .mac_avail   (mac_avail),
    .frame_sent  (frame_sent),
    .col_replay  (col_replay),
    .late_col    (late_col),
    .urun_retry  (urun_retry),
    .retry_fail  (retry_fail),
    .frames_held (frames_held)
);

// File: tb/tx_replay_fifo_tb.sv
`timescale 1ns/1ps
module tx_replay_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] drain_thresh = 12'd16;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        wr_last = 1'b0;
    logic        wr_ready;
    logic        mac_rd = 1'b0;
    logic        mac_urun = 1'b0;
    logic        mac_col = 1'b0;
    logic        tx_req, mac_avail, mac_last;
    logic [7:0]  mac_data;
    logic        frame_sent, col_replay, late_col, urun_retry, retry_fail;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    tx_replay_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .drain_thresh(drain_thresh),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
        .mac_rd(mac_rd), .mac_urun(mac_urun), .mac_col(mac_col),
        .tx_req(tx_req), .mac_avail(mac_avail), .mac_data(mac_data), .mac_last(mac_last),
        .frame_sent(frame_sent), .col_replay(col_replay), .late_col(late_col),
        .urun_retry(urun_retry), .retry_fail(retry_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        wr_last  = l;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic push_run(input logic [7:0] seed, input int from, input int upto, input logic end_it);
        for (int i = from; i < upto; i++) begin
            push(seed + 8'(i), end_it && (i == upto - 1));
        end
    endtask

    task automatic take(input logic [7:0] d, input logic l, input string req);
        @(negedge clk);
        while (!mac_avail) @(negedge clk);
        chk(req, mac_data, d);
        chk(req, mac_last, l);
        mac_rd = 1'b1;
        @(negedge clk);
        mac_rd = 1'b0;
    endtask

    task automatic take_frame(input logic [7:0] seed, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            take(seed + 8'(i), i == len - 1, req);
        end
        chk({req, " frame_sent"}, frame_sent, 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 mac_avail", mac_avail, 0);
        chk("R1 pulses", {frame_sent, col_replay, late_col, urun_retry, retry_fail}, 0);
    endtask

    task automatic t_threshold;
        drain_thresh = 12'd16;
        push_run(8'h10, 0, 15, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 below threshold", tx_req, 0);
        push_run(8'h10, 15, 16, 1'b0);
        chk("R3 one cycle before start", tx_req, 0);
        @(negedge clk);
        chk("R3 start at threshold", tx_req, 1);
        push_run(8'h10, 16, 40, 1'b1);
        take_frame(8'h10, 40, "R2 order");
    endtask

    task automatic t_short;
        drain_thresh = 12'd100;
        push_run(8'hA0, 0, 10, 1'b1);
        @(negedge clk);
        chk("R4 short frame start", tx_req, 1);
        take_frame(8'hA0, 10, "R4 data");
    endtask

    task automatic t_two_frames;
        drain_thresh = 12'd2047;
        push_run(8'h01, 0, 20, 1'b1);
        push_run(8'h31, 0, 20, 1'b1);
        @(negedge clk);
        chk("R5 two held blocks writes", wr_ready, 0);
        take_frame(8'h01, 20, "R5 first");
        chk("R5 gap cycle", tx_req, 0);
        @(negedge clk);
        chk("R5 second ready next cycle", tx_req, 1);
        chk("R5 writes reopen", wr_ready, 1);
        take_frame(8'h31, 20, "R5 second");
    endtask

    task automatic t_early_col;
        drain_thresh = 12'd2047;
        push_run(8'h40, 0, 100, 1'b1);
        for (int i = 0; i < 64; i++) take(8'h40 + 8'(i), 1'b0, "R6 before");
        @(negedge clk);
        mac_col = 1'b1;
        mac_rd  = 1'b1;
        @(negedge clk);
        mac_col = 1'b0;
        mac_rd  = 1'b0;
        chk("R6 replay pulse", col_replay, 1);
        chk("R12 no read with collision", frame_sent, 0);
        chk("R12 no underrun with collision", urun_retry, 0);
        chk("R6 tx_req low", tx_req, 0);
        take_frame(8'h40, 100, "R6 replay");
    endtask

    task automatic t_late_col;
        int sent_cnt;
        drain_thresh = 12'd2047;
        push_run(8'h80, 0, 100, 1'b1);
        for (int i = 0; i < 65; i++) take(8'h80 + 8'(i), 1'b0, "R7 before");
        @(negedge clk);
        mac_col = 1'b1;
        @(negedge clk);
        mac_col = 1'b0;
        chk("R7 late pulse", late_col, 1);
        chk("R7 no replay", col_replay, 0);
        sent_cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            sent_cnt += int'(frame_sent);
        end
        chk("R7 no frame_sent", sent_cnt, 0);
        push_run(8'hC0, 0, 5, 1'b1);
        take_frame(8'hC0, 5, "R7 next frame");
    endtask

    task automatic t_underrun;
        drain_thresh = 12'd8;
        push_run(8'h20, 0, 20, 1'b0);
        for (int i = 0; i < 20; i++) take(8'h20 + 8'(i), 1'b0, "R8 first try");
        @(negedge clk);
        chk("R8 starved", mac_avail, 0);
        mac_rd = 1'b1;
        @(negedge clk);
        mac_rd = 1'b0;
        chk("R8 urun pulse", urun_retry, 1);
        repeat (5) @(negedge clk);
        chk("R8 held until complete", tx_req, 0);
        push_run(8'h20, 20, 30, 1'b1);
        @(negedge clk);
        chk("R8 restart when complete", tx_req, 1);
        take_frame(8'h20, 30, "R8 resend");
        push_run(8'h50, 0, 8, 1'b0);
        @(negedge clk);
        chk("R9 threshold restored", tx_req, 1);
        push_run(8'h50, 8, 12, 1'b1);
        take_frame(8'h50, 12, "R9 data");
    endtask

    task automatic t_retry_limit;
        drain_thresh = 12'd2047;
        push_run(8'h60, 0, 10, 1'b1);
        for (int a = 0; a < 4; a++) begin
            take(8'h60, 1'b0, "R10 attempt start");
            @(negedge clk);
            mac_urun = 1'b1;
            @(negedge clk);
            mac_urun = 1'b0;
            chk("R10 retry pulse", urun_retry, (a < 3) ? 1 : 0);
            chk("R10 fail pulse", retry_fail, (a < 3) ? 0 : 1);
        end
        repeat (20) @(negedge clk);
        push_run(8'h70, 0, 3, 1'b1);
        take_frame(8'h70, 3, "R10 dropped");
    endtask

    task automatic t_capacity;
        drain_thresh = 12'd2047;
        push_run(8'h00, 0, 2048, 1'b1);
        @(negedge clk);
        chk("R11 full", wr_ready, 0);
        take_frame(8'h00, 2048, "R11 drain");
        chk("R11 space again", wr_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_threshold();
        t_short();
        t_two_frames();
        t_early_col();
        t_late_col();
        t_underrun();
        t_retry_limit();
        t_capacity();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule